// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Decoder

This block sits on the device side of an extended-data-out DRAM interface. A fast internal clock samples the active-low row strobe, column strobe, write enable and output enable. The block works out which kind of memory cycle the host is running from the order in which those strobes move. It then issues one-clock action strobes to an array model: latch a row, latch a column, read, write, or refresh a row. It also drives the data output enable. The output enable follows the extended-data-out rules: read data stays on the pins through column precharge in page mode, and it drops only when both strobes have returned high.

The decoder is a single state machine with six named states. ST_IDLE means the row strobe is high. ST_ROW means a row is open and no column has been taken yet. ST_COL means a column is active. ST_PAGE means column precharge inside an open row. ST_CBR means a refresh that starts with the column strobe already low. ST_SELF means self-refresh.

The transitions are as follows:
- ST_IDLE goes to ST_ROW on a row strobe fall while the column strobe is high.
- ST_IDLE goes to ST_CBR on a row strobe fall while the column strobe is low.
- ST_ROW goes to ST_COL on a column strobe fall.
- ST_COL goes to ST_PAGE on a column strobe rise.
- ST_PAGE goes back to ST_COL on the next column strobe fall.
- ST_CBR goes to ST_SELF once the row strobe has been low for SREF_CYC clocks.
- Every state with the row strobe low returns to ST_IDLE on a row strobe rise.

An internal refresh counter supplies the row for refreshes that start with the column strobe low. It wraps after REF_ROWS rows.

Top module: `edo_strobe_decoder`

## Requirements
- R1: After reset, all action strobes, dq_oe and self_ref are 0 and cyc_kind is 0. Every output reacts two clock edges after the input change that causes it, and each action strobe lasts one clock.
- R2: A row strobe fall while the column strobe is high pulses row_stb, loads row_addr with the full address and sets cyc_kind to 0 (unclassified).
- R3: A column strobe fall in an open row pulses col_stb and loads col_addr with the low COL_W address bits. With write enable high it also pulses rd_stb and sets cyc_kind to 1 (read). With write enable low it pulses wr_stb, sets cyc_kind to 2 (early write) and keeps dq_oe at 0.
- R4: A write enable fall during a read column pulses wr_stb once, sets cyc_kind to 3 (delayed write or read-modify-write) and turns dq_oe off.
- R5: A row strobe rise with no column strobe fall since the row strobe fell pulses ref_stb with ref_row equal to the latched row and sets cyc_kind to 4 (row-only refresh).
- R6: A row strobe fall while the column strobe is low and no read data is held pulses ref_stb with ref_row equal to the internal counter and sets cyc_kind to 5. The counter then increments, starting from 0 and wrapping to 0 after REF_ROWS-1.
- R7: The same fall while read data is still held is a hidden refresh. It pulses ref_stb from the counter, sets cyc_kind to 6 and leaves dq_oe on.
- R8: Read data stays enabled through a column strobe rise with the row strobe low, and through a row strobe rise with the column strobe low. It turns off once both strobes are high.
- R9: dq_oe is 0 whenever output enable is high and comes back when output enable returns low while read data is held.
- R10: When the row strobe stays low in ST_CBR for SREF_CYC clocks, self_ref rises and cyc_kind becomes 7. self_ref clears on the row strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed address |
| row_stb | output | 1 | Row latch pulse |
| row_addr | output | ADDR_W | Latched row |
| col_stb | output | 1 | Column latch pulse |
| col_addr | output | COL_W | Latched column |
| rd_stb | output | 1 | Read pulse |
| wr_stb | output | 1 | Write pulse |
| ref_stb | output | 1 | Refresh pulse |
| ref_row | output | ADDR_W | Row being refreshed |
| self_ref | output | 1 | Self-refresh active |
| dq_oe | output | 1 | Data output enable |
| cyc_kind | output | 3 | Cycle class code (see R2 to R10) |

## Verification
The assertions assume that the strobes are held steady for at least one sampling clock between transitions. They also assume that the host takes a column strobe fall or a write enable fall only while the row strobe is low. The stimulus changes inputs only on falling clock edges and holds each setting for two clocks. It never opens a column outside an open row, and it keeps output enable high through refresh-only sequences.

// File: rtl/edo_strobe_pkg.sv
package edo_strobe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PAGE,
        ST_CBR,
        ST_SELF
    } dec_state_e;

    typedef enum logic [2:0] {
        CY_NONE     = 3'd0,
        CY_READ     = 3'd1,
        CY_EARLY_WR = 3'd2,
        CY_LATE_WR  = 3'd3,
        CY_RAS_ONLY = 3'd4,
        CY_CBR      = 3'd5,
        CY_HIDDEN   = 3'd6,
        CY_SELF     = 3'd7
    } cyc_kind_e;

    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobes_t;

endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler
    import edo_strobe_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output strobes_t          cur,
    output logic [ADDR_W-1:0] addr_q,
    output logic              ras_fall,
    output logic              ras_rise,
    output logic              cas_fall,
    output logic              cas_rise,
    output logic              we_fall
);

    strobes_t prv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '1;
            prv    <= '1;
            addr_q <= '0;
        end else begin
            cur    <= '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n};
            prv    <= cur;
            addr_q <= addr;
        end
    end

    assign ras_fall = prv.ras  & ~cur.ras;
    assign ras_rise = ~prv.ras & cur.ras;
    assign cas_fall = prv.cas  & ~cur.cas;
    assign cas_rise = ~prv.cas & cur.cas;
    assign we_fall  = prv.we   & ~cur.we;

endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
    parameter int ROW_W = 11,
    parameter int ROWS  = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] cnt
);

    localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
    import edo_strobe_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int COL_W    = 10,
    parameter int SREF_CYC = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobes_t          cur,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_rise,
    input  logic              we_fall,
    input  logic [ADDR_W-1:0] ref_cnt,
    output logic              ref_inc,
    output logic              row_stb,
    output logic [ADDR_W-1:0] row_addr,
    output logic              col_stb,
    output logic [COL_W-1:0]  col_addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              ref_stb,
    output logic [ADDR_W-1:0] ref_row,
    output logic              self_ref,
    output logic              dq_oe,
    output cyc_kind_e         cyc
);

    localparam int SR_W = $clog2(SREF_CYC + 1);
    localparam logic [SR_W-1:0] SR_LAST = SR_W'(SREF_CYC - 1);

    dec_state_e      st, st_n;
    logic [SR_W-1:0] sref_cnt;
    logic            data_on, don_n;
    logic            col_rd;
    logic            col_evt;

    assign col_evt = (st == ST_ROW || st == ST_PAGE) && !ras_rise && cas_fall;
    assign ref_inc = (st == ST_IDLE) && ras_fall && !cur.cas;

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: if (ras_fall) st_n = cur.cas ? ST_ROW : ST_CBR;
            ST_ROW:  if (ras_rise) st_n = ST_IDLE; else if (cas_fall) st_n = ST_COL;
            ST_COL:  if (ras_rise) st_n = ST_IDLE; else if (cas_rise) st_n = ST_PAGE;
            ST_PAGE: if (ras_rise) st_n = ST_IDLE; else if (cas_fall) st_n = ST_COL;
            ST_CBR:  if (ras_rise) st_n = ST_IDLE; else if (sref_cnt == SR_LAST) st_n = ST_SELF;
            ST_SELF: if (ras_rise) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // read-data hold window
    always_comb begin
        don_n = data_on;
        if (we_fall)                 don_n = 1'b0;
        else if (col_evt)            don_n = cur.we;
        else if (cur.ras && cur.cas) don_n = 1'b0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_stb  <= 1'b0;
            row_addr <= '0;
            col_stb  <= 1'b0;
            col_addr <= '0;
            rd_stb   <= 1'b0;
            wr_stb   <= 1'b0;
            ref_stb  <= 1'b0;
            ref_row  <= '0;
            self_ref <= 1'b0;
            dq_oe    <= 1'b0;
            data_on  <= 1'b0;
            col_rd   <= 1'b0;
            sref_cnt <= '0;
            cyc      <= CY_NONE;
        end else begin
            row_stb  <= 1'b0;
            col_stb  <= 1'b0;
            rd_stb   <= 1'b0;
            wr_stb   <= 1'b0;
            ref_stb  <= 1'b0;
            data_on  <= don_n;
            dq_oe    <= don_n && !cur.oe;
            sref_cnt <= (st == ST_CBR && st_n == ST_CBR) ? sref_cnt + 1'b1 : '0;
            unique case (st)
                ST_IDLE: begin
                    if (ras_fall && cur.cas) begin
                        row_stb  <= 1'b1;
                        row_addr <= addr_q;
                        cyc      <= CY_NONE;
                    end else if (ras_fall) begin
                        ref_stb <= 1'b1;
                        ref_row <= ref_cnt;
                        cyc     <= data_on ? CY_HIDDEN : CY_CBR;
                    end
                end
                ST_ROW: begin
                    if (ras_rise) begin
                        ref_stb <= 1'b1;
                        ref_row <= row_addr;
                        cyc     <= CY_RAS_ONLY;
                    end
                end
                ST_COL: begin
                    if (!ras_rise && we_fall && col_rd) begin
                        wr_stb <= 1'b1;
                        col_rd <= 1'b0;
                        cyc    <= CY_LATE_WR;
                    end
                end
                ST_PAGE: begin
                end
                ST_CBR: begin
                    if (st_n == ST_SELF) begin
                        self_ref <= 1'b1;
                        cyc      <= CY_SELF;
                    end
                end
                ST_SELF: begin
                    if (ras_rise) self_ref <= 1'b0;
                end
                default: begin
                end
            endcase
            if (col_evt) begin
                col_stb  <= 1'b1;
                col_addr <= addr_q[COL_W-1:0];
                col_rd   <= cur.we;
                rd_stb   <= cur.we;
                wr_stb   <= !cur.we;
                cyc      <= cur.we ? CY_READ : CY_EARLY_WR;
            end
        end
    end

endmodule

// File: rtl/edo_strobe_decoder.sv
module edo_strobe_decoder
    import edo_strobe_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int COL_W    = 10,
    parameter int REF_ROWS = 2048,
    parameter int SREF_CYC = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              row_stb,
    output logic [ADDR_W-1:0] row_addr,
    output logic              col_stb,
    output logic [COL_W-1:0]  col_addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              ref_stb,
    output logic [ADDR_W-1:0] ref_row,
    output logic              self_ref,
    output logic              dq_oe,
    output logic [2:0]        cyc_kind
);

    strobes_t          cur;
    logic [ADDR_W-1:0] addr_q;
    logic              ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic [ADDR_W-1:0] ref_cnt;
    logic              ref_inc;
    cyc_kind_e         cyc;

    edo_strobe_sampler #(.ADDR_W(ADDR_W)) u_samp (
        .clk(clk), .rst_n(rst_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .cur(cur), .addr_q(addr_q),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall)
    );

    edo_refresh_ctr #(.ROW_W(ADDR_W), .ROWS(REF_ROWS)) u_rctr (
        .clk(clk), .rst_n(rst_n), .inc(ref_inc), .cnt(ref_cnt)
    );

    edo_cycle_fsm #(.ADDR_W(ADDR_W), .COL_W(COL_W), .SREF_CYC(SREF_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cur(cur), .addr_q(addr_q),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall),
        .ref_cnt(ref_cnt), .ref_inc(ref_inc),
        .row_stb(row_stb), .row_addr(row_addr),
        .col_stb(col_stb), .col_addr(col_addr),
        .rd_stb(rd_stb), .wr_stb(wr_stb),
        .ref_stb(ref_stb), .ref_row(ref_row),
        .self_ref(self_ref), .dq_oe(dq_oe), .cyc(cyc)
    );

    assign cyc_kind = cyc;

endmodule

// File: rtl/edo_strobe_chk.sv
module edo_strobe_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              row_stb,
    input logic [ADDR_W-1:0] row_addr,
    input logic              col_stb,
    input logic              wr_stb,
    input logic              ref_stb,
    input logic [ADDR_W-1:0] ref_row,
    input logic              self_ref,
    input logic              dq_oe,
    input logic [2:0]        cyc_kind
);

    logic [1:0] age;
    logic       aged;

    always_ff @(posedge clk) begin
        if (!rst_n)           age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign aged = (age == 2'd3);

    // R2
    row_from_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && row_stb) |-> (!$past(ras_n, 2) && $past(ras_n, 3) && $past(cas_n, 2)));

    // R3
    col_from_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && col_stb) |-> (!$past(cas_n, 2) && $past(cas_n, 3) && !$past(ras_n, 2)));

    // R4
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && wr_stb) |-> (!$past(we_n, 2) && !dq_oe));

    // R5
    ras_only_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && cyc_kind == 3'd4) |-> (ref_row == row_addr));

    // R8
    hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && dq_oe) |-> !($past(ras_n, 2) && $past(cas_n, 2)));

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && dq_oe) |-> !$past(oe_n, 2));

    // R10
    self_ras_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && self_ref) |-> !$past(ras_n, 2));

endmodule

bind edo_strobe_decoder edo_strobe_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .row_stb(row_stb), .row_addr(row_addr), .col_stb(col_stb), .wr_stb(wr_stb),
    .ref_stb(ref_stb), .ref_row(ref_row), .self_ref(self_ref), .dq_oe(dq_oe),
    .cyc_kind(cyc_kind)
);

// File: tb/edo_strobe_decoder_bench.sv
module edo_strobe_decoder_bench;

    localparam int ADDR_W   = 11;
    localparam int COL_W    = 10;
    localparam int REF_ROWS = 4;
    localparam int SREF_CYC = 50;

    localparam logic [4:0] E_ROW   = 5'b10000;
    localparam logic [4:0] E_COLRD = 5'b01100;
    localparam logic [4:0] E_COLWR = 5'b01010;
    localparam logic [4:0] E_WR    = 5'b00010;
    localparam logic [4:0] E_REF   = 5'b00001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              row_stb, col_stb, rd_stb, wr_stb, ref_stb, self_ref, dq_oe;
    logic [ADDR_W-1:0] row_addr, ref_row;
    logic [COL_W-1:0]  col_addr;
    logic [2:0]        cyc_kind;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct packed {
        logic [4:0]        stb;
        logic [ADDR_W-1:0] a;
        logic [2:0]        cyc;
    } ev_t;

    ev_t   exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    edo_strobe_decoder #(
        .ADDR_W(ADDR_W), .COL_W(COL_W), .REF_ROWS(REF_ROWS), .SREF_CYC(SREF_CYC)
    ) u_edo_strobe_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .row_stb(row_stb), .row_addr(row_addr), .col_stb(col_stb),
        .col_addr(col_addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .ref_stb(ref_stb),
        .ref_row(ref_row), .self_ref(self_ref), .dq_oe(dq_oe), .cyc_kind(cyc_kind)
    );

    // monitor: pops one expected event per observed strobe cycle
    always @(negedge clk) begin
        if (rst_n) begin
            logic [4:0]        s;
            logic [ADDR_W-1:0] a;
            ev_t               e;
            string             t;
            s = {row_stb, col_stb, rd_stb, wr_stb, ref_stb};
            if (s != 5'b0) begin
                a = row_stb ? row_addr : col_stb ? ADDR_W'(col_addr) : ref_stb ? ref_row : '0;
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected event: act stb=%b a=%h cyc=%0d exp none", s, a, cyc_kind);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (s !== e.stb || a !== e.a || cyc_kind !== e.cyc) begin
                        n_fail++;
                        $display("FAIL %s: act stb=%b a=%h cyc=%0d exp stb=%b a=%h cyc=%0d",
                                 t, s, a, cyc_kind, e.stb, e.a, e.cyc);
                    end
                end
            end
        end
    end

    task automatic expect_ev(input logic [4:0] s, input logic [ADDR_W-1:0] a,
                             input logic [2:0] cy, input string t);
        exp_q.push_back('{stb: s, a: a, cyc: cy});
        tag_q.push_back(t);
    endtask

    task automatic drive(input logic r, input logic c, input logic w, input logic o,
                         input logic [ADDR_W-1:0] a);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_bit(input string t, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%b exp=%b", t, act, exp);
        end
    endtask

    task automatic check_cyc(input string t, input logic [2:0] exp);
        n_chk++;
        if (cyc_kind !== exp) begin
            n_fail++;
            $display("FAIL %s: act cyc=%0d exp cyc=%0d", t, cyc_kind, exp);
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_bit("R1 strobes", row_stb | col_stb | rd_stb | wr_stb | ref_stb, 1'b0);
        check_bit("R1 dq_oe", dq_oe, 1'b0);
        check_bit("R1 self_ref", self_ref, 1'b0);
        check_cyc("R1 cyc_kind", 3'd0);

        // R2 R3 read, then page mode: R8 hold, R9 gate
        expect_ev(E_ROW, 11'h155, 3'd0, "R2 row latch");
        drive(0, 1, 1, 0, 11'h155);
        expect_ev(E_COLRD, 11'h3AB, 3'd1, "R3 read column");
        drive(0, 0, 1, 0, 11'h3AB);
        check_bit("R3 read enables output", dq_oe, 1'b1);
        drive(0, 1, 1, 0, 11'h000);
        check_bit("R8 page precharge hold", dq_oe, 1'b1);
        expect_ev(E_COLRD, 11'h3FF, 3'd1, "R3 column low bits");
        drive(0, 0, 1, 0, 11'h7FF);
        drive(0, 0, 1, 1, 11'h7FF);
        check_bit("R9 oe high gates", dq_oe, 1'b0);
        drive(0, 0, 1, 0, 11'h7FF);
        check_bit("R9 oe low restores", dq_oe, 1'b1);
        drive(0, 1, 1, 0, 11'h000);
        check_bit("R8 cas rise ras low", dq_oe, 1'b1);
        drive(1, 1, 1, 0, 11'h000);
        check_bit("R8 both high off", dq_oe, 1'b0);

        // R7 hidden refresh, counter at 0
        expect_ev(E_ROW, 11'h012, 3'd0, "R2 row latch");
        drive(0, 1, 1, 0, 11'h012);
        expect_ev(E_COLRD, 11'h012, 3'd1, "R3 read column");
        drive(0, 0, 1, 0, 11'h012);
        drive(1, 0, 1, 0, 11'h000);
        check_bit("R8 ras rise cas low", dq_oe, 1'b1);
        expect_ev(E_REF, 11'h000, 3'd6, "R7 hidden refresh");
        drive(0, 0, 1, 0, 11'h000);
        check_bit("R7 data kept", dq_oe, 1'b1);
        drive(1, 0, 1, 0, 11'h000);
        drive(1, 1, 1, 0, 11'h000);
        check_bit("R8 off after hidden", dq_oe, 1'b0);

        // R6 column-before-row refresh, counter at 1
        drive(1, 0, 1, 1, 11'h000);
        expect_ev(E_REF, 11'h001, 3'd5, "R6 counter refresh");
        drive(0, 0, 1, 1, 11'h000);
        drive(1, 0, 1, 1, 11'h000);
        drive(1, 1, 1, 1, 11'h000);

        // R3 early write
        expect_ev(E_ROW, 11'h300, 3'd0, "R2 row latch");
        drive(0, 1, 1, 0, 11'h300);
        expect_ev(E_COLWR, 11'h021, 3'd2, "R3 early write");
        drive(0, 0, 0, 0, 11'h021);
        check_bit("R3 early write output off", dq_oe, 1'b0);
        drive(1, 1, 1, 0, 11'h000);

        // R4 delayed write after read
        expect_ev(E_ROW, 11'h444, 3'd0, "R2 row latch");
        drive(0, 1, 1, 0, 11'h444);
        expect_ev(E_COLRD, 11'h044, 3'd1, "R3 read column");
        drive(0, 0, 1, 0, 11'h444);
        check_bit("R4 read before write", dq_oe, 1'b1);
        expect_ev(E_WR, 11'h000, 3'd3, "R4 delayed write");
        drive(0, 0, 0, 0, 11'h444);
        check_bit("R4 write turns output off", dq_oe, 1'b0);
        drive(1, 1, 1, 0, 11'h000);

        // R5 row-only refresh
        expect_ev(E_ROW, 11'h0AA, 3'd0, "R2 row latch");
        drive(0, 1, 1, 1, 11'h0AA);
        expect_ev(E_REF, 11'h0AA, 3'd4, "R5 row-only refresh");
        drive(1, 1, 1, 1, 11'h555);

        // R6 counter 2, 3 then wrap to 0
        for (int k = 2; k < 5; k++) begin
            drive(1, 0, 1, 1, 11'h000);
            expect_ev(E_REF, ADDR_W'(k % REF_ROWS), 3'd5, "R6 counter wrap");
            drive(0, 0, 1, 1, 11'h000);
            drive(1, 0, 1, 1, 11'h000);
            drive(1, 1, 1, 1, 11'h000);
        end

        // R10 self refresh, counter at 1
        drive(1, 0, 1, 1, 11'h000);
        expect_ev(E_REF, 11'h001, 3'd5, "R6 refresh before self");
        drive(0, 0, 1, 1, 11'h000);
        repeat (SREF_CYC - 10) @(negedge clk);
        check_bit("R10 not yet self", self_ref, 1'b0);
        repeat (20) @(negedge clk);
        check_bit("R10 self entered", self_ref, 1'b1);
        check_cyc("R10 self code", 3'd7);
        drive(1, 0, 1, 1, 11'h000);
        check_bit("R10 self exits", self_ref, 1'b0);
        drive(1, 1, 1, 1, 11'h000);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 pending events: act=%0d exp=0", exp_q.size());
        end
        finish_run();
    end

endmodule